// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a small word-addressed cache that sits between a processor request port and a backing memory. Every set holds two lines; each line carries a valid flag, a dirty flag, a tag and a single data word, and each set keeps one bit that records which of its two lines was used least recently. A request that hits finishes in the cycle it is presented. A request that misses stalls the processor while the cache fetches the word over a blocking request/acknowledge port. If the line being replaced is dirty, the cache first writes that line back.

The request address has no offset bits, because a line is one word. The low `IDX_W = log2(SETS)` bits select the set and the remaining upper bits form the tag. Writes use write-back with write-allocate. While `req_ready` is low the processor keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` stable. The number of sets, the address width and the word width are parameters.

Top module: `cache2w_top`

## Requirements
- R1: The set index is `req_addr[IDX_W-1:0]` and the tag is the remaining upper address bits. A request hits only if one of the two lines in that set is valid and holds the same tag. At most one line of a set ever matches.
- R2: A hit raises `req_ready` and `rsp_hit` in the same cycle as the valid request. On a read hit `rsp_rdata` is the cached word in that cycle. A hit issues no memory request.
- R3: On a miss with an empty line in the set, the word goes into way 0 if way 0 is empty, and otherwise into way 1.
- R4: On a miss with both lines valid, the least recently used line is replaced. Every hit and every fill, read or write, marks the other way of that set as least recent.
- R5: A write hit changes only the cached word and marks the line dirty. Memory is not written until that line is evicted.
- R6: When the replaced line is valid and dirty, the cache first issues a memory write (`mem_write`=1) of that line's word to the address rebuilt from its tag and the set index. The refill read starts only after that write is acknowledged. A clean victim causes no memory write. The memory address stays stable while a request waits for `mem_ack`.
- R7: A write miss allocates the line. It reads the word from memory, replaces it with the write data, and leaves the line valid and dirty, with no memory write of the new data at that time.
- R8: On a miss, `req_ready` stays low until the cycle in which the refill read is acknowledged. In that cycle `req_ready` is 1, `rsp_hit` is 0 and, for a read, `rsp_rdata` equals `mem_rdata`.
- R9: Reset clears every valid, dirty and LRU bit. After reset, the first access to any address misses, and no memory request is made while in reset.
- R10: With 2 sets, the reads 0,2,0,1,4,0 give miss, miss, hit, miss, miss, hit, and address 4 evicts address 2. After reset, the reads 0,2,0,4,2 give miss, miss, hit, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request completes this cycle |
| rsp_hit | output | 1 | Completing request hit |
| rsp_rdata | output | DATA_W | Read data, valid with req_ready |
| mem_req | output | 1 | Memory request pending |
| mem_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Refill data, valid with mem_ack |

## Verification
A wrong tag or valid bit shows on the next access to that set as a hit or miss flag that disagrees with the model. On a false hit it also shows as wrong read data. A wrong LRU bit or a lost dirty flag only appears when the set is next forced to evict. The symptom is a missing, extra or misaddressed write-back, or stale data returned a few accesses later. The bench therefore replays a long mixed read/write stream over more addresses than the cache holds. For every access it compares the hit flag, the data, the count and content of write-backs, and the order of write-back and refill.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   localparam int NWAYS = 2;
   typedef enum logic [1:0] {
      ST_LOOKUP = 2'd0,
      ST_EVICT  = 2'd1,
      ST_REFILL = 2'd2
   } cstate_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
   parameter int SETS   = 2,
   parameter int TAG_W  = 7,
   parameter int DATA_W = 16,
   parameter int IDX_W  = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_match,
   output logic              lk_valid,
   output logic              lk_dirty,
   output logic [TAG_W-1:0]  lk_tag_out,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic              wr_dirty,
   input  logic [DATA_W-1:0] wr_data
);
   logic [SETS-1:0]   valid_q;
   logic [SETS-1:0]   dirty_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[lk_idx] <= 1'b1;
         dirty_q[lk_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[lk_idx]  <= lk_tag;
         data_q[lk_idx] <= wr_data;
      end
   end

   assign lk_valid   = valid_q[lk_idx];
   assign lk_dirty   = dirty_q[lk_idx];
   assign lk_tag_out = tag_q[lk_idx];
   assign lk_data    = data_q[lk_idx];
   assign lk_match   = lk_valid && (tag_q[lk_idx] == lk_tag);

   // a_r9_clean_after_reset: the cycle after reset no line is valid
   a_r9_clean_after_reset: assert property (@(posedge clk)
      !rst_n |=> (valid_q == '0) && (dirty_q == '0));
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
   parameter int SETS  = 2,
   parameter int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             touch_en,
   input  logic             touch_way,
   output logic             lru_way
);
   logic [SETS-1:0] lru_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        lru_q <= '0;
      else if (touch_en) lru_q[idx] <= ~touch_way;
   end

   assign lru_way = lru_q[idx];

   // a_r4_touch_marks_other: a touched way is never least recent next cycle
   a_r4_touch_marks_other: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (lru_way != $past(touch_way)) || (idx != $past(idx)));
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
   import cache2w_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_write,
   input  logic [1:0] hit_vec,
   input  logic [1:0] valid_vec,
   input  logic [1:0] dirty_vec,
   input  logic       lru_way,
   input  logic       mem_ack,
   output logic       req_ready,
   output logic       rsp_hit,
   output logic       use_mem_data,
   output logic       mem_req,
   output logic       mem_write,
   output logic       sel_way,
   output logic [1:0] wr_en,
   output logic       wr_dirty,
   output logic       wr_from_mem,
   output logic       touch_en,
   output logic       touch_way
);
   cstate_e st_q, st_d;
   logic    vic_q, vic_d, victim;

   assign victim = !valid_vec[0] ? 1'b0 : (!valid_vec[1] ? 1'b1 : lru_way);

   always_comb begin
      st_d         = st_q;
      vic_d        = vic_q;
      req_ready    = 1'b0;
      rsp_hit      = 1'b0;
      use_mem_data = 1'b0;
      mem_req      = 1'b0;
      mem_write    = 1'b0;
      sel_way      = vic_q;
      wr_en        = '0;
      wr_dirty     = 1'b0;
      wr_from_mem  = 1'b0;
      touch_en     = 1'b0;
      touch_way    = vic_q;
      case (st_q)
         ST_LOOKUP: begin
            if (req_valid) begin
               if (|hit_vec) begin
                  req_ready = 1'b1;
                  rsp_hit   = 1'b1;
                  sel_way   = hit_vec[1];
                  touch_en  = 1'b1;
                  touch_way = hit_vec[1];
                  wr_en     = req_write ? hit_vec : 2'b00;
                  wr_dirty  = 1'b1;
               end else begin
                  vic_d = victim;
                  st_d  = (valid_vec[victim] && dirty_vec[victim]) ? ST_EVICT : ST_REFILL;
               end
            end
         end
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_write = 1'b1;
            if (mem_ack) st_d = ST_REFILL;
         end
         ST_REFILL: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               req_ready    = 1'b1;
               use_mem_data = 1'b1;
               wr_en[vic_q] = 1'b1;
               wr_dirty     = req_write;
               wr_from_mem  = !req_write;
               touch_en     = 1'b1;
               st_d         = ST_LOOKUP;
            end
         end
         default: st_d = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_LOOKUP;
         vic_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         vic_q <= vic_d;
      end
   end

   // a_r8_stall_while_waiting: no completion while memory is outstanding
   a_r8_stall_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |-> !req_ready);
   // a_r6_fill_after_writeback: an acknowledged write-back is followed by a refill read
   a_r6_fill_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_write && mem_ack) |=> (mem_req && !mem_write));
   // a_r2_hit_no_memory: a hit never uses the memory port
   a_r2_hit_no_memory: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (!mem_req && req_ready));
   // a_r9_no_mem_in_reset: memory request low during reset
   a_r9_no_mem_in_reset: assert property (@(posedge clk)
      !rst_n |=> !mem_req);
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
   import cache2w_pkg::*;
#(
   parameter int SETS   = 2,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_req,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("cache2w_top: SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("cache2w_top: ADDR_W must exceed log2(SETS)");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("cache2w_top: DATA_W must be positive");
   end

   logic [IDX_W-1:0]              idx;
   logic [TAG_W-1:0]              tag;
   logic [NWAYS-1:0]              w_match, w_valid, w_dirty, wr_en;
   logic [NWAYS-1:0][TAG_W-1:0]   w_tag;
   logic [NWAYS-1:0][DATA_W-1:0]  w_data;
   logic [DATA_W-1:0]             wr_data;
   logic lru_way, use_mem_data, sel_way, wr_dirty, wr_from_mem, touch_en, touch_way;

   assign idx = req_addr[IDX_W-1:0];
   assign tag = req_addr[ADDR_W-1:IDX_W];
   assign wr_data = wr_from_mem ? mem_rdata : req_wdata;

   for (genvar g = 0; g < NWAYS; g++) begin : g_way
      cache2w_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) way_i (
         .clk(clk), .rst_n(rst_n),
         .lk_idx(idx), .lk_tag(tag),
         .lk_match(w_match[g]), .lk_valid(w_valid[g]), .lk_dirty(w_dirty[g]),
         .lk_tag_out(w_tag[g]), .lk_data(w_data[g]),
         .wr_en(wr_en[g]), .wr_dirty(wr_dirty), .wr_data(wr_data)
      );
   end

   cache2w_lru #(.SETS(SETS)) lru_i (
      .clk(clk), .rst_n(rst_n), .idx(idx),
      .touch_en(touch_en), .touch_way(touch_way), .lru_way(lru_way)
   );

   cache2w_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .hit_vec(w_match), .valid_vec(w_valid), .dirty_vec(w_dirty),
      .lru_way(lru_way), .mem_ack(mem_ack),
      .req_ready(req_ready), .rsp_hit(rsp_hit), .use_mem_data(use_mem_data),
      .mem_req(mem_req), .mem_write(mem_write), .sel_way(sel_way),
      .wr_en(wr_en), .wr_dirty(wr_dirty), .wr_from_mem(wr_from_mem),
      .touch_en(touch_en), .touch_way(touch_way)
   );

   assign rsp_rdata = use_mem_data ? mem_rdata : w_data[sel_way];
   assign mem_addr  = mem_write ? {w_tag[sel_way], idx} : req_addr;
   assign mem_wdata = w_data[sel_way];

   // a_r1_single_match: a tag is never held twice in one set
   a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(w_match));
   // a_r6_addr_stable: memory address held while waiting for acknowledge
   a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: tb/cache2w_tb.sv
module cache2w_top_tb_top;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int LAT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_hit, mem_req, mem_write;
   logic [DW-1:0] rsp_rdata, mem_wdata;
   logic [AW-1:0] mem_addr;
   logic mem_ack;
   logic [DW-1:0] mem_rdata;

   always #2 clk = ~clk;

   cache2w_top #(.SETS(2), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // backing memory model
   logic [DW-1:0] mem [256];
   logic inited = 1'b0;
   int wait_cnt, wb_total, rd_total, rd_at_wb;
   logic [AW-1:0] last_wb_addr;
   logic [DW-1:0] last_wb_data;

   always @(posedge clk) begin
      if (!inited) begin
         for (int i = 0; i < 256; i++) mem[i] <= DW'(i * 16'h0101) ^ 16'h5A00;
         inited <= 1'b1;
         wb_total <= 0; rd_total <= 0; rd_at_wb <= 0;
         mem_rdata <= '0;
      end
      if (!rst_n) begin
         mem_ack <= 1'b0; wait_cnt <= 0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            if (wait_cnt == LAT) begin
               wait_cnt <= 0;
               mem_ack  <= 1'b1;
               if (mem_write) begin
                  mem[mem_addr] <= mem_wdata;
                  wb_total     <= wb_total + 1;
                  rd_at_wb     <= rd_total;
                  last_wb_addr <= mem_addr;
                  last_wb_data <= mem_wdata;
               end else begin
                  mem_rdata <= mem[mem_addr];
                  rd_total  <= rd_total + 1;
               end
            end else wait_cnt <= wait_cnt + 1;
         end
      end
   end

   int checks = 0, errors = 0;
   logic [DW-1:0] truth [256];
   logic          m_valid [2][2], m_dirty [2][2];
   logic [AW-2:0] m_tag   [2][2];
   logic [DW-1:0] m_data  [2][2];
   logic          m_lru   [2];
   logic          last_hit;

   task automatic chk(input logic ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < 2; s++) begin
         m_lru[s] = 1'b0;
         for (int w = 0; w < 2; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; end
      end
      for (int i = 0; i < 256; i++) truth[i] = mem[i];
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(!mem_req && !req_ready, "R9 idle in reset", {mem_req, req_ready}, 0);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic do_access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic s, hit, way, exp_wb;
      logic [AW-1:0] wb_a;
      logic [DW-1:0] wb_d, exp_rd;
      int wb0, rd0, cyc;
      logic got_hit;
      logic [DW-1:0] got_rd;
      s = a[0]; hit = 0; way = 0; exp_wb = 0; wb_a = '0; wb_d = '0;
      for (int w = 0; w < 2; w++)
         if (m_valid[s][w] && m_tag[s][w] == a[AW-1:1]) begin hit = 1; way = w[0]; end
      if (!hit) begin
         way = !m_valid[s][0] ? 1'b0 : (!m_valid[s][1] ? 1'b1 : m_lru[s]);
         exp_wb = m_valid[s][way] && m_dirty[s][way];
         wb_a = {m_tag[s][way], s};
         wb_d = m_data[s][way];
         m_valid[s][way] = 1; m_tag[s][way] = a[AW-1:1];
         m_dirty[s][way] = wr;
         m_data[s][way] = wr ? d : truth[a];
      end else if (wr) begin
         m_data[s][way] = d; m_dirty[s][way] = 1;
      end
      m_lru[s] = ~way;
      exp_rd = truth[a];

      @(negedge clk);
      wb0 = wb_total; rd0 = rd_total;
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      #1; cyc = 0;
      while (!req_ready && cyc < 100) begin @(negedge clk); #1; cyc++; end
      got_hit = rsp_hit; got_rd = rsp_rdata;
      @(posedge clk); #1;
      req_valid = 0;
      if (wr) truth[a] = d;
      last_hit = got_hit;

      chk(cyc < 100, "R8 completion", cyc, 0);
      chk(got_hit == hit, "R1 R3 R4 hit flag", got_hit, hit);
      chk(hit ? (cyc == 0) : (cyc > 0), "R2 R8 latency", cyc, hit ? 0 : 1);
      if (!wr) chk(got_rd == exp_rd, "R2 R8 R7 read data", got_rd, exp_rd);
      chk((wb_total - wb0) == (exp_wb ? 1 : 0), "R5 R6 R7 write-back count", wb_total - wb0, exp_wb);
      chk((rd_total - rd0) == (hit ? 0 : 1), "R2 R8 refill count", rd_total - rd0, !hit);
      if (exp_wb && wb_total != wb0) begin
         chk(last_wb_addr == wb_a, "R6 write-back address", last_wb_addr, wb_a);
         chk(last_wb_data == wb_d, "R6 write-back data", last_wb_data, wb_d);
         chk(rd_at_wb == rd0, "R6 write-back before refill", rd_at_wb, rd0);
      end
   endtask

   initial begin
      logic [AW-1:0] s1 [7];
      logic [5:0] e1;
      logic [AW-1:0] s2 [5];
      logic [4:0] e2;
      logic [31:0] lcg;
      s1 = '{8'd0, 8'd2, 8'd0, 8'd1, 8'd4, 8'd0, 8'd2};
      e1 = 6'b100100;
      s2 = '{8'd0, 8'd2, 8'd0, 8'd4, 8'd2};
      e2 = 5'b00100;
      do_reset();

      // R10: first sequence, then 2 must miss (evicted by 4)
      for (int i = 0; i < 7; i++) begin
         do_access(1'b0, s1[i], '0);
         if (i < 6) chk(last_hit == e1[i], "R10 sequence one", last_hit, e1[i]);
         else       chk(!last_hit, "R10 address 4 evicted 2", last_hit, 0);
      end
      do_reset();
      for (int i = 0; i < 5; i++) begin
         do_access(1'b0, s2[i], '0);
         chk(last_hit == e2[i], "R10 sequence two", last_hit, e2[i]);
      end

      // R5 R6 R7: directed dirty path
      do_reset();
      do_access(1'b1, 8'd0, 16'hA0A0);   // R7 write miss allocate into way 0 (R3)
      do_access(1'b1, 8'd2, 16'hB2B2);   // R7 second empty way
      do_access(1'b1, 8'd0, 16'hC0C0);   // R5 write hit, no write-back
      do_access(1'b0, 8'd4, '0);         // R6 evicts dirty 2
      do_access(1'b0, 8'd2, '0);         // R6 evicts dirty 0, reads B2B2
      do_access(1'b0, 8'd0, '0);         // reads C0C0 back from memory

      // R9: reset drops cached lines
      do_reset();
      do_access(1'b0, 8'd2, '0);
      chk(!last_hit, "R9 miss after reset", last_hit, 0);

      // mixed stream sweep over 16 addresses
      lcg = 32'h1234_5678;
      for (int i = 0; i < 900; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         if (i == 450) do_reset();
         do_access(lcg[20], {4'd0, lcg[27:24]}, lcg[15:0]);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
   end
endmodule